// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog Timer

The block is a watchdog timer controlled from a simple 32-bit register bus. A 20-bit counter counts down by one on each pulse of a slow reference strobe, for as long as the block is running. Software controls it by writing 16-bit key words to a command register. The keys stop the count, restart it, reload it to full scale, acknowledge the interrupt, and open or close a write window. A second register shows the upper sixteen bits of the counter when read. A write to it sets those bits and clears the four lowest bits, but only while the write window is open.

If the counter runs down to zero, the block latches an interrupt and pulses a system-reset request. A forced restart works as follows: stop the count, load a very small value, then restart it. The reset request then follows about sixteen reference strobes later.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is stopped and locked, the counter holds 0xFFFFF, `irq` is 0 and `rst_req` is 0.
- R2: While stopped, `tick` leaves the counter unchanged. While running, each cycle with `tick` high lowers the counter by exactly one until it reaches zero. Key 0x4A4B starts counting and key 0x3877 stops it.
- R3: A read at byte offset 0x04 returns counter bits [19:4] in `rdata[15:0]`, with zeros in `rdata[31:16]`. A read at offset 0x00 returns zero.
- R4: A write to offset 0x04 while unlocked loads `wdata[15:0]` into counter bits [19:4] and zeros into bits [3:0]. While locked the write has no effect.
- R5: Key 0xAB00 written to offset 0x00 unlocks count writes, and key 0xAB01 locks them again.
- R6: Key 0xDEAF loads 0xFFFFF into the counter, whether the block is locked or unlocked.
- R7: When a running counter steps from 1 to 0, the counter then stays at 0, `irq` rises, and `rst_req` is high for exactly one clock. The request does not repeat while the counter sits at zero.
- R8: `irq` stays set until key 0x7482 is written. If an expiry and that key arrive in the same cycle, `irq` ends up set.
- R9: A command write is accepted only when `wdata[31:16]` is zero and `wdata[15:0]` is one of the six keys. Any other value written to offset 0x00 has no effect.
- R10: A count load or full-scale reload in the same cycle as a `tick` takes precedence, so the loaded value is not decremented.
- R11: Stopping, loading a count of 1 and restarting makes `rst_req` pulse on the 16th tick after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference strobe, one clock wide per count step |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | 1 | Latched expiry interrupt |
| rst_req | output | 1 | One-clock system-reset request on expiry |

## Verification
The counter, the run flag and the lock flag are internal, but any error in them reaches the ports quickly. A wrong counter value appears at the next read of offset 0x04, apart from the four hidden low bits. Those low bits show up through the number of ticks to expiry, which the sweeps measure to the exact tick. A wrong lock or run flag changes the result of the very next count write or tick, and the bench reads the counter back straight after each such event. A wrong expiry decision appears at `rst_req` and `irq` one clock after the deciding tick.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam int unsigned KEY_W = 16;

   // Byte offsets on the register bus
   localparam int unsigned OFF_CMD = 0;
   localparam int unsigned OFF_CNT = 4;

   // Command keys
   localparam logic [KEY_W-1:0] KEY_HALT = 16'h3877;
   localparam logic [KEY_W-1:0] KEY_RUN  = 16'h4A4B;
   localparam logic [KEY_W-1:0] KEY_ACK  = 16'h7482;
   localparam logic [KEY_W-1:0] KEY_OPEN = 16'hAB00;
   localparam logic [KEY_W-1:0] KEY_SEAL = 16'hAB01;
   localparam logic [KEY_W-1:0] KEY_FULL = 16'hDEAF;

   // One-cycle control strobes from the decoder to the counter
   typedef struct packed {
      logic halt;
      logic run;
      logic ack;
      logic full;
      logic load;
   } wdk_ctl_t;
endpackage

// File: rtl/wdk_key_decode.sv
module wdk_key_decode
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned VIEW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output wdk_ctl_t          ctl,
   output logic [VIEW_W-1:0] load_val,
   output logic              unlocked
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT);

   logic             is_cmd;
   logic [KEY_W-1:0] key;

   always_comb begin
      key    = wdata[KEY_W-1:0];
      is_cmd = wr_en && (addr == A_CMD) && (wdata[DATA_W-1:KEY_W] == '0);
      ctl.halt = is_cmd && (key == KEY_HALT);
      ctl.run  = is_cmd && (key == KEY_RUN);
      ctl.ack  = is_cmd && (key == KEY_ACK);
      ctl.full = is_cmd && (key == KEY_FULL);
      ctl.load = wr_en && (addr == A_CNT) && unlocked;
      load_val = wdata[VIEW_W-1:0];
   end

   // Write window: opened and closed only by its two keys
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (is_cmd && (key == KEY_OPEN)) begin
         unlocked <= 1'b1;
      end else if (is_cmd && (key == KEY_SEAL)) begin
         unlocked <= 1'b0;
      end
   end
endmodule

// File: rtl/wdk_down_counter.sv
module wdk_down_counter
   import wdk_pkg::*;
#(
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned VIEW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  wdk_ctl_t          ctl,
   input  logic [VIEW_W-1:0] load_val,
   output logic [CNT_W-1:0]  cnt,
   output logic              running,
   output logic              irq,
   output logic              rst_req
);
   localparam int unsigned     LOW_W = CNT_W - VIEW_W;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] load_full;
   logic             step;
   logic             expire;

   // Placement of the written field inside the counter
   generate
      if (LOW_W > 0) begin : g_pad
         assign load_full = {load_val, {LOW_W{1'b0}}};
      end else begin : g_flat
         assign load_full = load_val;
      end
   endgenerate

   always_comb begin
      step   = running && tick && (cnt != '0) && !ctl.load && !ctl.full;
      expire = step && (cnt == ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '1;
         running <= 1'b0;
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         if (ctl.load) begin
            cnt <= load_full;
         end else if (ctl.full) begin
            cnt <= '1;
         end else if (step) begin
            cnt <= cnt - ONE;
         end

         if (ctl.halt) begin
            running <= 1'b0;
         end else if (ctl.run) begin
            running <= 1'b1;
         end

         if (expire) begin
            irq <= 1'b1;
         end else if (ctl.ack) begin
            irq <= 1'b0;
         end

         rst_req <= expire;
      end
   end
endmodule

// File: rtl/wdk_read_port.sv
module wdk_read_port
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned VIEW_W = 16
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [VIEW_W-1:0] view,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT);

   always_comb begin
      if (rd_en && (addr == A_CNT)) begin
         rdata = DATA_W'(view);
      end else begin
         rdata = '0;
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned VIEW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              rst_req
);
   localparam int unsigned LOW_W = CNT_W - VIEW_W;

   generate
      if (VIEW_W > CNT_W) begin : g_bad_view
         $error("VIEW_W must not exceed CNT_W");
      end
      if (DATA_W < KEY_W || VIEW_W > DATA_W) begin : g_bad_data
         $error("DATA_W must hold a key and the counter view");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   wdk_ctl_t          ctl;
   logic [VIEW_W-1:0] load_val;
   logic              unlocked;
   logic [CNT_W-1:0]  cnt;
   logic              running;

   wdk_key_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VIEW_W(VIEW_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .ctl      (ctl),
      .load_val (load_val),
      .unlocked (unlocked)
   );

   wdk_down_counter #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ctl      (ctl),
      .load_val (load_val),
      .cnt      (cnt),
      .running  (running),
      .irq      (irq),
      .rst_req  (rst_req)
   );

   wdk_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VIEW_W(VIEW_W)) u_rd (
      .rd_en (rd_en),
      .addr  (addr),
      .view  (cnt[CNT_W-1:LOW_W]),
      .rdata (rdata)
   );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
   import wdk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned VIEW_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input wdk_ctl_t          ctl,
   input logic [CNT_W-1:0]  cnt,
   input logic              running,
   input logic              irq,
   input logic              rst_req,
   input logic [DATA_W-1:0] rdata
);
   logic no_write;
   assign no_write = !ctl.load && !ctl.full;

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r7_req_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> irq);

   a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && no_write) |=> (cnt == '0));

   a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && no_write) |=> $stable(cnt));

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && cnt != '0 && no_write) |=> (cnt == $past(cnt) - CNT_W'(1)));

   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ctl.ack) |=> irq);

   a_r6_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.full && !ctl.load) |=> (cnt == '1));

   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:VIEW_W] == '0);
endmodule

bind keyed_watchdog wdk_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .ctl     (ctl),
   .cnt     (cnt),
   .running (running),
   .irq     (irq),
   .rst_req (rst_req),
   .rdata   (rdata)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic        rst_req;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   localparam logic [7:0] A_CMD = 8'h00;
   localparam logic [7:0] A_CNT = 8'h04;

   keyed_watchdog u_keyed_watchdog (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t = 1'b0);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; tick = t;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic load_count(input logic [15:0] v);
      wr(A_CMD, 32'h0000_AB00);
      wr(A_CNT, {16'h0, v});
      wr(A_CMD, 32'h0000_AB01);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
      rd(A_CNT, v); chk("R1 full count", v, 32'h0000_FFFF);
      pulse(20);
      rd(A_CNT, v); chk("R1 R2 stopped at reset", v, 32'h0000_FFFF);
      wr(A_CNT, 32'h0000_0042);
      rd(A_CNT, v); chk("R1 R4 locked at reset", v, 32'h0000_FFFF);

      // R3 command offset reads zero
      rd(A_CMD, v); chk("R3 command read", v, 32'h0);

      // R4 R5 load sweep: walking ones plus patterns, upper write bits discarded
      for (int i = 0; i < 18; i++) begin
         logic [15:0] pat;
         pat = (i < 16) ? (16'h1 << i) : ((i == 16) ? 16'hFFFF : 16'hA5C3);
         wr(A_CMD, 32'h0000_AB00);
         wr(A_CNT, {16'hBEEF, pat});
         rd(A_CNT, v); chk("R4 R5 unlocked load", v, {16'h0, pat});
      end
      wr(A_CMD, 32'h0000_AB01);
      wr(A_CNT, 32'h0000_1234);
      rd(A_CNT, v); chk("R4 R5 locked load ignored", v, 32'h0000_A5C3);

      // R6 full reload while locked
      wr(A_CMD, 32'h0000_DEAF);
      rd(A_CNT, v); chk("R6 reload when locked", v, 32'h0000_FFFF);

      // R2 countdown sweep: k*16 - n remaining, low nibble hidden
      for (int k = 1; k <= 3; k++) begin
         for (int n = 0; n < k * 16; n += 3) begin
            wr(A_CMD, 32'h0000_3877);
            load_count(16'(k));
            wr(A_CMD, 32'h0000_4A4B);
            pulse(n);
            wr(A_CMD, 32'h0000_3877);
            pulse(2);
            rd(A_CNT, v); chk("R2 countdown", v, 32'((k * 16 - n) >> 4));
            chk("R2 no early irq", {31'h0, irq}, 32'h0);
         end
      end

      // R11 R7 forced restart: expiry on 16th tick
      wr(A_CMD, 32'h0000_3877);
      load_count(16'h0001);
      wr(A_CMD, 32'h0000_4A4B);
      pulse(15);
      chk("R11 no req at 15", {31'h0, rst_req}, 32'h0);
      chk("R11 no irq at 15", {31'h0, irq}, 32'h0);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R11 R7 req on 16th", {31'h0, rst_req}, 32'h1);
      chk("R7 irq set", {31'h0, irq}, 32'h1);
      @(negedge clk);
      chk("R7 req one clock", {31'h0, rst_req}, 32'h0);
      pulse(5);
      chk("R7 no repeat", {31'h0, rst_req}, 32'h0);
      rd(A_CNT, v); chk("R7 holds zero", v, 32'h0);

      // R9 R8 bad keys leave irq pending, good key clears
      wr(A_CMD, 32'h0001_7482);
      chk("R9 upper bits nonzero", {31'h0, irq}, 32'h1);
      wr(A_CMD, 32'h0000_7483);
      chk("R9 unknown key", {31'h0, irq}, 32'h1);
      wr(A_CNT, 32'h0000_7482);
      chk("R8 R9 key at count offset", {31'h0, irq}, 32'h1);
      wr(A_CMD, 32'h0000_7482);
      chk("R8 cleared by key", {31'h0, irq}, 32'h0);

      // R9 halt key with upper bits set does not stop counting
      wr(A_CMD, 32'h0000_DEAF);
      wr(A_CMD, 32'h0000_4A4B);
      wr(A_CMD, 32'h8000_3877);
      pulse(32);
      rd(A_CNT, v); chk("R9 bad halt ignored", v, 32'h0000_FFFD);
      wr(A_CMD, 32'h0000_3877);

      // R10 load and reload win over a simultaneous tick
      wr(A_CMD, 32'h0000_4A4B);
      wr(A_CMD, 32'h0000_AB00);
      wr(A_CNT, 32'h0000_0001, 1'b1);
      wr(A_CMD, 32'h0000_AB01);
      pulse(15);
      chk("R10 load beats tick", {31'h0, rst_req}, 32'h0);
      wr(A_CMD, 32'h0000_DEAF, 1'b1);
      wr(A_CMD, 32'h0000_3877);
      rd(A_CNT, v); chk("R10 reload beats tick", v, 32'h0000_FFFF);

      // R8 expiry wins over a same-cycle clear
      load_count(16'h0001);
      wr(A_CMD, 32'h0000_4A4B);
      pulse(15);
      wr(A_CMD, 32'h0000_7482, 1'b1);
      chk("R8 set beats clear", {31'h0, irq}, 32'h1);
      wr(A_CMD, 32'h0000_7482);
      chk("R8 clear after", {31'h0, irq}, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule